// File: doc/BRIEF.md
# Page Unit Inversion Encoder Decoder

This block sits in the data path of a multi-level-cell flash controller, between the host side and the error-correction encoder. Each cell holds two bits, and the two symbols whose upper bit is 1 (10 and 11) sit at high threshold voltages, where charge leakage causes most retention errors. In encode mode the block takes a page as a byte stream and cuts it into fixed-size units. It counts the high symbols in each unit and inverts the unit when high symbols are the majority. It emits the unit, then records one tag bit per unit for the spare area.

In restore mode the block takes the decoded page together with the stored tag vector. It re-inverts every unit whose tag is set, so the original bytes come back. Encode holds one whole unit before emitting it, because the decision needs the full count. Restore passes bytes straight through.

Both byte streams use valid/ready. A byte moves on a rising edge where valid and ready are both high. While `out_valid` is high and `out_ready` is low, the encoder holds the same byte on `out_data`. When both unit buffers are occupied, `in_ready` drops, and no byte is lost. In restore mode `in_ready` follows `out_ready` and `out_valid` follows `in_valid`. `mode` may change only between pages, when no byte is in flight.

Top module: `pui_codec`

## Requirements
- R1: After reset `out_valid`, `page_done` and `tag_out` are 0, and in encode mode (`mode` = 0) `in_ready` is 1.
- R2: Each byte holds four two-bit symbols at bits [7:6], [5:4], [3:2] and [1:0]. A symbol counts as high when its upper bit (bit 7, 5, 3 or 1) is 1. A unit of UNIT_BYTES bytes is inverted when its high count is greater than 2*UNIT_BYTES.
- R3: A unit whose high count equals exactly 2*UNIT_BYTES is not inverted, and its tag bit is 0.
- R4: An inverted unit is emitted with all 8 bits of every byte complemented. A unit that is not inverted is emitted unchanged, and bytes keep their input order.
- R5: In encode mode no byte of unit k leaves the block before the last byte of unit k has been accepted.
- R6: While `out_valid` is 1 and `out_ready` is 0 in encode mode, `out_valid` stays 1 and `out_data` stays unchanged on the next cycle. No byte is dropped or repeated under any pattern of back-pressure.
- R7: With `in_valid` and `out_ready` held high in encode mode, `in_ready` never drops, so the block sustains one byte per cycle.
- R8: Bit k of `tag_out` is the tag of unit k, with unit 0 in bit 0. `tag_out` changes only together with a one-cycle `page_done` pulse. That pulse is high in the cycle after the handshake of the page's last output byte.
- R9: In restore mode a high `tag_load` captures `tag_in`. Each output byte is the input byte, complemented when the captured tag bit of its unit is 1. `in_ready` equals `out_ready` and `out_valid` equals `in_valid`, and at page end `tag_out` shows the captured vector.
- R10: Encoding a page and then restoring its output with the produced `tag_out` returns the original page bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = encode (write path), 1 = restore (read path) |
| tag_load | input | 1 | Capture `tag_in` for restore |
| tag_in | input | UNITS | Stored tag vector, unit 0 in bit 0 |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts an input byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts an output byte |
| out_data | output | 8 | Output byte |
| tag_out | output | UNITS | Tag vector of the last finished page |
| page_done | output | 1 | One-cycle strobe after the last byte of a page |

## Verification
A directed page puts four unit shapes side by side:
- an all-ones unit, which must be inverted;
- an all-zeros unit, which must pass unchanged;
- an exact tie, which shows that equality does not invert;
- a unit one high symbol past the tie, which shows that the comparison is strict.

The directed page is run without gaps, which shows whether the two buffers really overlap filling and draining. Random pages with a random share of high-biased bytes, and random valid and ready gaps on both sides, expose order loss, dropped bytes and early release under back-pressure. Each encoded page is fed back through restore, and restore also runs on random data with arbitrary tags, which separates tag indexing errors from inversion errors.

// File: rtl/pui_pkg.sv
package pui_pkg;

  typedef enum logic {
    PUI_ENCODE  = 1'b0,
    PUI_RESTORE = 1'b1
  } pui_mode_e;

  // Number of high-voltage symbols in a byte: symbols whose upper bit is 1.
  function automatic logic [2:0] upper_ones(input logic [7:0] b);
    return 3'(b[7]) + 3'(b[5]) + 3'(b[3]) + 3'(b[1]);
  endfunction

endpackage

// File: rtl/pui_high_counter.sv
module pui_high_counter #(
  parameter int UNIT_BYTES = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       last,
  input  logic [7:0] data,
  output logic       invert
);
  import pui_pkg::*;

  localparam int HALF = UNIT_BYTES * 2;
  localparam int CW   = $clog2(UNIT_BYTES * 4 + 1);

  logic [CW-1:0] acc;
  logic [CW-1:0] total;

  assign total  = acc + CW'(upper_ones(data));
  assign invert = total > CW'(HALF);

  always_ff @(posedge clk) begin
    if (!rst_n)    acc <= '0;
    else if (step) acc <= last ? '0 : total;
  end
endmodule

// File: rtl/pui_pingpong.sv
module pui_pingpong #(
  parameter int UNIT_BYTES = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wr_invert,
  output logic       wr_room,
  output logic       wr_last,
  input  logic       rd_en,
  output logic       rd_avail,
  output logic [7:0] rd_data,
  output logic       rd_invert,
  output logic       rd_last
);
  localparam int IW = (UNIT_BYTES > 1) ? $clog2(UNIT_BYTES) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(UNIT_BYTES - 1);

  logic [1:0]    full;
  logic [1:0]    inv;
  logic          wr_bank;
  logic          rd_bank;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] rd_idx;
  logic [7:0]    bank_q [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [7:0] store [UNIT_BYTES];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b))) store[wr_idx] <= wr_data;
    end
    assign bank_q[b] = store[rd_idx];
  end

  assign wr_room   = !full[wr_bank];
  assign wr_last   = (wr_idx == LAST_IDX);
  assign rd_avail  = full[rd_bank];
  assign rd_invert = inv[rd_bank];
  assign rd_last   = (rd_idx == LAST_IDX);
  assign rd_data   = bank_q[rd_bank] ^ {8{inv[rd_bank]}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= '0;
      inv     <= '0;
      wr_bank <= 1'b0;
      rd_bank <= 1'b0;
      wr_idx  <= '0;
      rd_idx  <= '0;
    end else begin
      if (wr_en) begin
        if (wr_last) begin
          full[wr_bank] <= 1'b1;
          inv[wr_bank]  <= wr_invert;
          wr_bank       <= ~wr_bank;
          wr_idx        <= '0;
        end else begin
          wr_idx <= wr_idx + 1'b1;
        end
      end
      if (rd_en) begin
        if (rd_last) begin
          full[rd_bank] <= 1'b0;
          rd_bank       <= ~rd_bank;
          rd_idx        <= '0;
        end else begin
          rd_idx <= rd_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pui_tag_pack.sv
module pui_tag_pack #(
  parameter int UNITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             flag,
  output logic [(UNITS>1 ? $clog2(UNITS) : 1)-1:0] unit_idx,
  output logic [UNITS-1:0] tag_vec,
  output logic             done
);
  localparam int UW = (UNITS > 1) ? $clog2(UNITS) : 1;
  localparam logic [UW-1:0] LAST_UNIT = UW'(UNITS - 1);

  logic [UNITS-1:0] acc;
  logic [UNITS-1:0] merged;

  always_comb begin
    merged           = acc;
    merged[unit_idx] = flag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      tag_vec  <= '0;
      done     <= 1'b0;
      unit_idx <= '0;
    end else begin
      done <= 1'b0;
      if (step) begin
        if (unit_idx == LAST_UNIT) begin
          tag_vec  <= merged;
          done     <= 1'b1;
          acc      <= '0;
          unit_idx <= '0;
        end else begin
          acc      <= merged;
          unit_idx <= unit_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pui_codec.sv
module pui_codec #(
  parameter int UNIT_BYTES = 512,
  parameter int UNITS      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode,
  input  logic             tag_load,
  input  logic [UNITS-1:0] tag_in,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic [UNITS-1:0] tag_out,
  output logic             page_done
);
  import pui_pkg::*;

  localparam int IW = (UNIT_BYTES > 1) ? $clog2(UNIT_BYTES) : 1;
  localparam int UW = (UNITS > 1) ? $clog2(UNITS) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(UNIT_BYTES - 1);

  logic          restore;
  logic          wr_en, wr_room, wr_last, wr_invert;
  logic          rd_en, rd_avail, rd_invert, rd_last;
  logic [7:0]    rd_data;
  logic [IW-1:0] r_idx;
  logic [UNITS-1:0] loaded;
  logic [UW-1:0] unit_idx;
  logic          restore_flip;
  logic          out_fire;
  logic          unit_step;
  logic          unit_flag;

  assign restore      = (mode == PUI_RESTORE);
  assign restore_flip = loaded[unit_idx];

  assign in_ready  = restore ? out_ready : wr_room;
  assign out_valid = restore ? in_valid  : rd_avail;
  assign out_data  = restore ? (in_data ^ {8{restore_flip}}) : rd_data;

  assign wr_en     = !restore && in_valid && wr_room;
  assign rd_en     = !restore && rd_avail && out_ready;
  assign out_fire  = out_valid && out_ready;
  assign unit_step = restore ? (out_fire && (r_idx == LAST_IDX)) : (rd_en && rd_last);
  assign unit_flag = restore ? restore_flip : rd_invert;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loaded <= '0;
      r_idx  <= '0;
    end else begin
      if (tag_load) loaded <= tag_in;
      if (restore && out_fire) r_idx <= (r_idx == LAST_IDX) ? '0 : r_idx + 1'b1;
    end
  end

  pui_high_counter #(.UNIT_BYTES(UNIT_BYTES)) u_count (
    .clk(clk), .rst_n(rst_n), .step(wr_en), .last(wr_last),
    .data(in_data), .invert(wr_invert)
  );

  pui_pingpong #(.UNIT_BYTES(UNIT_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(in_data), .wr_invert(wr_invert),
    .wr_room(wr_room), .wr_last(wr_last),
    .rd_en(rd_en), .rd_avail(rd_avail), .rd_data(rd_data),
    .rd_invert(rd_invert), .rd_last(rd_last)
  );

  pui_tag_pack #(.UNITS(UNITS)) u_tags (
    .clk(clk), .rst_n(rst_n), .step(unit_step), .flag(unit_flag),
    .unit_idx(unit_idx), .tag_vec(tag_out), .done(page_done)
  );
endmodule

// File: rtl/pui_codec_chk.sv
module pui_codec_chk #(
  parameter int UNIT_BYTES = 512,
  parameter int UNITS      = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic [UNITS-1:0] tag_out,
  input logic             page_done
);
  import pui_pkg::*;

  localparam int HALF = UNIT_BYTES * 2;
  localparam int CW   = $clog2(UNIT_BYTES * 4 + 1);
  localparam int IW   = (UNIT_BYTES > 1) ? $clog2(UNIT_BYTES) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(UNIT_BYTES - 1);

  logic [IW-1:0] seen_idx;
  logic [CW-1:0] seen_high;
  logic          enc_fire;

  assign enc_fire = !mode && out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_idx  <= '0;
      seen_high <= '0;
    end else if (enc_fire) begin
      if (seen_idx == LAST_IDX) begin
        seen_idx  <= '0;
        seen_high <= '0;
      end else begin
        seen_idx  <= seen_idx + 1'b1;
        seen_high <= seen_high + CW'(upper_ones(out_data));
      end
    end
  end

  AST_UNIT_LOW_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_fire && seen_idx == LAST_IDX) |-> ((seen_high + CW'(upper_ones(out_data))) <= CW'(HALF))); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6

  AST_DONE_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |-> $past(out_valid && out_ready)); // R8

  AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !page_done |-> $stable(tag_out)); // R8
endmodule

bind pui_codec pui_codec_chk #(.UNIT_BYTES(UNIT_BYTES), .UNITS(UNITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .tag_out(tag_out),
  .page_done(page_done)
);

// File: tb/pui_codec_test.sv
`timescale 1ns/1ps
module pui_codec_test;
  localparam int UB = 16;
  localparam int NU = 4;
  localparam int PB = UB * NU;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode;
  logic          tag_load;
  logic [NU-1:0] tag_in;
  logic          in_valid;
  logic          in_ready;
  logic [7:0]    in_data;
  logic          out_valid;
  logic          out_ready;
  logic [7:0]    out_data;
  logic [NU-1:0] tag_out;
  logic          page_done;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [7:0] src  [PB];
  logic [7:0] orig [PB];
  logic [7:0] got  [PB];
  int stalls;

  always #10 clk = ~clk;

  pui_codec #(.UNIT_BYTES(UB), .UNITS(NU)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tag_load(tag_load), .tag_in(tag_in),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .tag_out(tag_out), .page_done(page_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int high_of(input logic [7:0] b);
    return int'(b[7]) + int'(b[5]) + int'(b[3]) + int'(b[1]);
  endfunction

  function automatic bit unit_inverts(input int u);
    int s = 0;
    for (int i = 0; i < UB; i++) s += high_of(src[u*UB + i]);
    return s > 2*UB;
  endfunction

  function automatic logic [NU-1:0] enc_tags();
    logic [NU-1:0] t;
    for (int u = 0; u < NU; u++) t[u] = unit_inverts(u);
    return t;
  endfunction

  // Runs one page through the block; exp_tags is the tag vector expected with page_done.
  task automatic run_page(input bit rmode, input int gap_in, input int gap_out,
                          input logic [NU-1:0] exp_tags);
    int ip = 0, op = 0, cyc = 0, last_cyc = -10, done_seen = 0;
    bit pend_stall = 0;
    logic [7:0] stall_data = 8'h00;
    stalls = 0;
    while ((op < PB || cyc <= last_cyc + 1) && cyc < 5000) begin
      @(negedge clk);
      if (page_done) begin
        done_seen++;
        chk("R8 page_done cycle", cyc, last_cyc + 1);
        chk("R8 tag_out vector", 32'(tag_out), 32'(exp_tags));
      end
      if (pend_stall && !rmode) begin
        chk("R6 valid held under stall", 32'(out_valid), 32'd1);
        chk("R6 data held under stall", 32'(out_data), 32'(stall_data));
      end
      in_valid  = (ip < PB) && (($urandom % 100) >= gap_in);
      in_data   = (ip < PB) ? src[ip] : 8'h00;
      out_ready = ($urandom % 100) >= gap_out;
      #1;
      if (rmode) begin
        chk("R9 in_ready follows out_ready", 32'(in_ready), 32'(out_ready));
        chk("R9 out_valid follows in_valid", 32'(out_valid), 32'(in_valid));
      end
      pend_stall = out_valid && !out_ready;
      stall_data = out_data;
      if (in_valid && !in_ready) stalls++;
      if (out_valid && out_ready && op < PB) begin
        if (!rmode) chk("R5 unit complete before release", 32'(ip >= (op/UB + 1)*UB), 32'd1);
        got[op] = out_data;
        if (op == PB - 1) last_cyc = cyc;
        op++;
      end
      if (in_valid && in_ready) ip++;
      cyc++;
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b0;
    chk("R8 one page_done per page", done_seen, 1);
    chk("R6 all bytes delivered", op, PB);
  endtask

  task automatic encode_and_check(input int gi, input int go, input string tag);
    logic [NU-1:0] et;
    et = enc_tags();
    mode = 1'b0;
    run_page(1'b0, gi, go, et);
    for (int i = 0; i < PB; i++)
      chk({"R4 encoded byte ", tag}, 32'(got[i]), 32'(src[i] ^ {8{et[i/UB]}}));
  endtask

  task automatic restore_page(input logic [NU-1:0] tags, input int gi, input int go);
    @(negedge clk);
    mode = 1'b1;
    tag_in = tags;
    tag_load = 1'b1;
    @(negedge clk);
    tag_load = 1'b0;
    run_page(1'b1, gi, go, tags);
    for (int i = 0; i < PB; i++)
      chk("R9 restored byte", 32'(got[i]), 32'(src[i] ^ {8{tags[i/UB]}}));
    @(negedge clk);
    mode = 1'b0;
  endtask

  task automatic round_trip(input int gi, input int go, input string tag);
    logic [NU-1:0] t;
    for (int i = 0; i < PB; i++) orig[i] = src[i];
    encode_and_check(gi, go, tag);
    t = tag_out;
    for (int i = 0; i < PB; i++) src[i] = got[i];
    restore_page(t, gi, go);
    for (int i = 0; i < PB; i++) chk("R10 round trip byte", 32'(got[i]), 32'(orig[i]));
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20417));
    rst_n = 1'b0; mode = 1'b0; tag_load = 1'b0; tag_in = '0;
    in_valid = 1'b0; in_data = 8'h00; out_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
    chk("R1 page_done after reset", 32'(page_done), 32'd0);
    chk("R1 tag_out after reset", 32'(tag_out), 32'd0);
    chk("R1 in_ready after reset", 32'(in_ready), 32'd1);

    // Directed page: ones, zeros, exact tie, tie plus one high symbol.
    for (int i = 0; i < UB; i++) begin
      src[i]        = 8'hFF;
      src[UB + i]   = 8'h00;
      src[2*UB + i] = (i < UB/2) ? 8'hFF : 8'h00;
      src[3*UB + i] = (i < UB/2) ? 8'hFF : 8'h00;
    end
    src[3*UB + UB/2] = 8'h80;
    encode_and_check(0, 0, "directed");
    chk("R7 no input stall at full rate", stalls, 0);
    chk("R8 directed tag vector", 32'(tag_out), 32'h9);
    chk("R3 tie unit passes unchanged", 32'(got[2*UB]), 32'hFF);
    chk("R2 one over tie is inverted", 32'(got[3*UB]), 32'h00);
    chk("R2 all-ones unit inverted", 32'(got[0]), 32'h00);
    for (int i = 0; i < PB; i++) src[i] = got[i];
    for (int i = 0; i < UB; i++) begin
      orig[i] = 8'hFF; orig[UB+i] = 8'h00;
      orig[2*UB+i] = (i < UB/2) ? 8'hFF : 8'h00;
      orig[3*UB+i] = (i < UB/2) ? 8'hFF : 8'h00;
    end
    orig[3*UB + UB/2] = 8'h80;
    restore_page(4'h9, 0, 0);
    for (int i = 0; i < PB; i++) chk("R10 directed round trip", 32'(got[i]), 32'(orig[i]));

    // Random pages with biased content and random gaps on both sides.
    for (int p = 0; p < 8; p++) begin
      int bias = $urandom % 100;
      for (int i = 0; i < PB; i++) begin
        logic [7:0] b = 8'($urandom);
        src[i] = (($urandom % 100) < bias) ? (b | 8'hAA) : b;
      end
      round_trip($urandom % 60, $urandom % 60, "random");
    end

    // Restore with arbitrary tags on random data.
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < PB; i++) src[i] = 8'($urandom);
      restore_page(NU'($urandom), $urandom % 40, $urandom % 40);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule